// File: doc/BRIEF.md
# Clock-Sweep Replacement Frame Picker

This block picks which of a fixed set of physical frames gives up its page when a new page has to be brought in. It holds two status bits per frame: a "used" bit that any access sets, and a "changed" bit that only a write sets. A hand register points at the frame where the next search begins. A search sweeps the frames in circular order, one frame per clock. The least valuable class of frame wins: not used and unchanged first, then not used but changed, then used but unchanged, and used and changed last.

The sweep runs in alternating passes. A quiet pass looks only for frames with both bits clear and alters nothing. A clearing pass looks for unused but changed frames and clears the used bit of every frame it passes over. The two alternate until a frame qualifies. The result is a one-cycle done pulse that carries the frame index and a dirty flag, which tells the caller that the old contents must be written back before reuse. The hand then moves to the frame after the one chosen. A load input clears both bits of a frame once a fresh page has been placed in it. Accesses keep updating the bits while a search is under way.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset both bits of every frame are 0, the hand points at frame 0, `req_ready` is 1 and `done` is 0.
- R2: An access with `acc_write`=0 sets the used bit of `acc_frame`. An access with `acc_write`=1 sets both the used and the changed bit of that frame.
- R3: A load clears both bits of `fill_frame`. When an access names the same frame in the same cycle, the access wins for the bits it sets and the load clears the rest.
- R4: A search begins at the hand and examines one frame per clock in ascending circular order, wrapping from frame NFRAMES-1 to frame 0. `done` is seen after exactly as many rising edges, counted from the edge that accepted the request, as there were frames examined.
- R5: The first pass, and every odd-numbered pass after it, takes the first frame with used=0 and changed=0, and changes no bit.
- R6: The even-numbered passes take the first frame with used=0 and changed=1, as judged before any clearing. Such a pass clears the used bit of every frame it examines and does not take.
- R7: When no access or load occurs during a search, a frame is chosen within 4×NFRAMES examined frames.
- R8: `victim_frame` holds the chosen index and `victim_dirty` holds the changed bit the frame had when it was examined. Both are valid while `done` is 1.
- R9: After a frame is chosen, the hand points at the next frame in circular order, and the next search starts there.
- R10: Accesses that arrive during a search update the bits. Later passes of the same search see those updates.
- R11: `req_ready` is 1 only while no search is running. A request is taken when `req_valid` and `req_ready` are both 1. `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A frame is being accessed this cycle |
| acc_write | input | 1 | The access is a write |
| acc_frame | input | IDX_W | Frame being accessed |
| fill_valid | input | 1 | A new page has been loaded into a frame |
| fill_frame | input | IDX_W | Frame that was loaded |
| req_valid | input | 1 | Request to pick a frame |
| req_ready | output | 1 | Picker is idle and takes a request |
| done | output | 1 | One-cycle pulse: a frame has been chosen |
| victim_frame | output | IDX_W | Index of the chosen frame |
| victim_dirty | output | 1 | Chosen frame holds changed data |

## Verification
The hardest case to reach is a search that only ends in the fourth pass. That needs every frame to be both used and changed, so the picker must clear all the used bits and then come back to find a frame that has become unused but changed. The stimulus gets there by loading every frame and then writing to all of them before the request. It then continues without reloading, so the next search finds such frames in its second pass. A write sent in the first scan cycle of a search shows that a frame's class can change during the search. A load and an access sent to the same frame in the same cycle show which of the two takes priority.

// File: rtl/cvp_pkg.sv
package cvp_pkg;

   // Sweep pass: which (used, changed) class the current pass accepts.
   typedef enum logic [0:0] {
      PASS_QUIET = 1'b0,   // accept (0,0), touch nothing
      PASS_CLEAR = 1'b1    // accept (0,1), strip used bits while passing
   } sweep_pass_e;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } sweep_state_e;

   // Bound on frames examined by an undisturbed search, per frame count.
   localparam int unsigned SWEEP_PASSES_MAX = 4;

endpackage

// File: rtl/cvp_bit_bank.sv
module cvp_bit_bank #(
   parameter  int unsigned NFRAMES = 8,
   localparam int unsigned IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [IDX_W-1:0]   acc_frame,
   input  logic               fill_valid,
   input  logic [IDX_W-1:0]   fill_frame,
   input  logic               sweep_clr,
   input  logic [IDX_W-1:0]   sweep_idx,
   output logic [NFRAMES-1:0] used_vec,
   output logic [NFRAMES-1:0] chg_vec
);

   initial begin : p_param_chk
      assert (NFRAMES >= 2) else $error("cvp_bit_bank: NFRAMES must be at least 2");
   end

   for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
      logic hit_acc;
      logic hit_fill;
      logic hit_sweep;
      logic used_q;
      logic chg_q;

      assign hit_acc   = acc_valid  && (acc_frame  == IDX_W'(i));
      assign hit_fill  = fill_valid && (fill_frame == IDX_W'(i));
      assign hit_sweep = sweep_clr  && (sweep_idx  == IDX_W'(i));

      // Used bit: any access sets it; a load or a clearing pass drops it.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            used_q <= 1'b0;
         end else if (hit_acc) begin
            used_q <= 1'b1;
         end else if (hit_fill || hit_sweep) begin
            used_q <= 1'b0;
         end
      end

      // Changed bit: only a write sets it; only a load drops it.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chg_q <= 1'b0;
         end else if (hit_acc && acc_write) begin
            chg_q <= 1'b1;
         end else if (hit_fill) begin
            chg_q <= 1'b0;
         end
      end

      assign used_vec[i] = used_q;
      assign chg_vec[i]  = chg_q;
   end

   // R2
   wr_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> (used_vec[$past(acc_frame)] && chg_vec[$past(acc_frame)]));

   // R2
   rd_sets_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> used_vec[$past(acc_frame)]);

   // R3
   fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !(acc_valid && (acc_frame == fill_frame)))
      |=> (!used_vec[$past(fill_frame)] && !chg_vec[$past(fill_frame)]));

endmodule

// File: rtl/cvp_frame_eval.sv
module cvp_frame_eval #(
   parameter  int unsigned NFRAMES = 8,
   localparam int unsigned IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input  logic [NFRAMES-1:0]   used_vec,
   input  logic [NFRAMES-1:0]   chg_vec,
   input  logic [IDX_W-1:0]     sel,
   input  cvp_pkg::sweep_pass_e pass,
   output logic                 sel_used,
   output logic                 sel_chg,
   output logic                 take,
   output logic                 strip
);
   import cvp_pkg::*;

   logic [1:0] cls;

   assign sel_used = used_vec[sel];
   assign sel_chg  = chg_vec[sel];
   assign cls      = {sel_used, sel_chg};

   // Class accepted by each pass; the clearing pass strips used frames.
   always_comb begin
      take  = 1'b0;
      strip = 1'b0;
      unique case (pass)
         PASS_QUIET: take = (cls == 2'b00);
         PASS_CLEAR: begin
            take  = (cls == 2'b01);
            strip = sel_used;
         end
         default: begin
            take  = 1'b0;
            strip = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cvp_sweep_ctrl.sv
module cvp_sweep_ctrl #(
   parameter  int unsigned NFRAMES = 8,
   localparam int unsigned IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1,
   localparam int unsigned CNT_W   = IDX_W + 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 take,
   input  logic                 strip,
   input  logic                 sel_chg,
   input  logic                 disturb,
   output logic [IDX_W-1:0]     sel,
   output cvp_pkg::sweep_pass_e pass,
   output logic                 sweep_clr,
   output logic                 done,
   output logic [IDX_W-1:0]     victim_frame,
   output logic                 victim_dirty
);
   import cvp_pkg::*;

   localparam logic [IDX_W-1:0] LAST      = IDX_W'(NFRAMES - 1);
   localparam int unsigned      SCAN_MAX  = SWEEP_PASSES_MAX * NFRAMES;

   sweep_state_e     state_q;
   sweep_pass_e      pass_q;
   logic [IDX_W-1:0] cur_q;
   logic [IDX_W-1:0] step_q;
   logic [IDX_W-1:0] hand_q;
   logic [IDX_W-1:0] cur_nxt;
   logic             done_q;
   logic [IDX_W-1:0] vic_q;
   logic             vdirty_q;
   logic             scanning;

   assign scanning = (state_q == ST_SCAN);

   // Circular successor: free wrap for a power-of-two frame count.
   if ((1 << IDX_W) == NFRAMES) begin : g_wrap_pow2
      assign cur_nxt = cur_q + 1'b1;
   end else begin : g_wrap_cmp
      assign cur_nxt = (cur_q == LAST) ? '0 : cur_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pass_q   <= PASS_QUIET;
         cur_q    <= '0;
         step_q   <= '0;
         hand_q   <= '0;
         done_q   <= 1'b0;
         vic_q    <= '0;
         vdirty_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_SCAN;
                  cur_q   <= hand_q;
                  step_q  <= '0;
                  pass_q  <= PASS_QUIET;
               end
            end
            ST_SCAN: begin
               if (take) begin
                  done_q   <= 1'b1;
                  vic_q    <= cur_q;
                  vdirty_q <= sel_chg;
                  hand_q   <= cur_nxt;
                  state_q  <= ST_IDLE;
               end else begin
                  cur_q <= cur_nxt;
                  if (step_q == LAST) begin
                     step_q <= '0;
                     pass_q <= (pass_q == PASS_QUIET) ? PASS_CLEAR : PASS_QUIET;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = !scanning;
   assign sel          = cur_q;
   assign pass         = pass_q;
   assign sweep_clr    = scanning && strip && !take;
   assign done         = done_q;
   assign victim_frame = vic_q;
   assign victim_dirty = vdirty_q;

   // Checker state: scan length and whether the bits were touched.
   logic [CNT_W-1:0] scan_cnt_q;
   logic             touched_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_cnt_q <= '0;
         touched_q  <= 1'b0;
      end else if (!scanning) begin
         scan_cnt_q <= '0;
         touched_q  <= 1'b0;
      end else begin
         if (scan_cnt_q != '1) scan_cnt_q <= scan_cnt_q + 1'b1;
         if (disturb) touched_q <= 1'b1;
      end
   end

   // R7
   scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scanning && !touched_q) |-> (scan_cnt_q < CNT_W'(SCAN_MAX)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !done));

   // R9
   hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (victim_frame != LAST)) |-> (hand_q == victim_frame + 1'b1));

endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
   parameter  int unsigned NFRAMES = 8,
   localparam int unsigned IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [IDX_W-1:0] acc_frame,
   input  logic             fill_valid,
   input  logic [IDX_W-1:0] fill_frame,
   input  logic             req_valid,
   output logic             req_ready,
   output logic             done,
   output logic [IDX_W-1:0] victim_frame,
   output logic             victim_dirty
);
   import cvp_pkg::*;

   logic [NFRAMES-1:0] used_vec;
   logic [NFRAMES-1:0] chg_vec;
   logic [IDX_W-1:0]   sel;
   sweep_pass_e        pass;
   logic               sel_used;
   logic               sel_chg;
   logic               take;
   logic               strip;
   logic               sweep_clr;
   logic               disturb;

   assign disturb = acc_valid || fill_valid;

   cvp_bit_bank #(.NFRAMES(NFRAMES)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_frame  (acc_frame),
      .fill_valid (fill_valid),
      .fill_frame (fill_frame),
      .sweep_clr  (sweep_clr),
      .sweep_idx  (sel),
      .used_vec   (used_vec),
      .chg_vec    (chg_vec)
   );

   cvp_frame_eval #(.NFRAMES(NFRAMES)) u_eval (
      .used_vec (used_vec),
      .chg_vec  (chg_vec),
      .sel      (sel),
      .pass     (pass),
      .sel_used (sel_used),
      .sel_chg  (sel_chg),
      .take     (take),
      .strip    (strip)
   );

   cvp_sweep_ctrl #(.NFRAMES(NFRAMES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .take         (take),
      .strip        (strip),
      .sel_chg      (sel_chg),
      .disturb      (disturb),
      .sel          (sel),
      .pass         (pass),
      .sweep_clr    (sweep_clr),
      .done         (done),
      .victim_frame (victim_frame),
      .victim_dirty (victim_dirty)
   );

   // R5: a quiet pass never strips a used bit.
   quiet_no_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pass == PASS_QUIET) |-> !sweep_clr);

   // R6: a frame that is stripped still had its used bit set.
   strip_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_clr |-> sel_used);

endmodule

// File: tb/clock_victim_picker_bench.sv
module clock_victim_picker_bench;

   localparam int unsigned NF = 4;
   localparam int unsigned IW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          acc_valid, acc_write, fill_valid, req_valid;
   logic [IW-1:0] acc_frame, fill_frame;
   logic          req_ready, done, victim_dirty;
   logic [IW-1:0] victim_frame;

   int errors = 0;
   int checks = 0;

   always #10ns clk = ~clk;

   clock_victim_picker #(.NFRAMES(NF)) u_clock_victim_picker (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_frame(acc_frame),
      .fill_valid(fill_valid), .fill_frame(fill_frame),
      .req_valid(req_valid), .req_ready(req_ready),
      .done(done), .victim_frame(victim_frame), .victim_dirty(victim_dirty)
   );

   // Row: keep = skip reloading all frames; ops = 2 bits per frame
   // (0 none, 1 read, 2 write); expected frame, dirty flag, frames examined.
   typedef struct packed {
      logic       keep;
      logic [7:0] ops;
      logic [1:0] exp_idx;
      logic       exp_dirty;
      logic [7:0] exp_lat;
   } row_t;

   localparam row_t ROWS [8] = '{
      '{1'b0, 8'b00000000, 2'd0, 1'b0, 8'd1},
      '{1'b0, 8'b00000100, 2'd2, 1'b0, 8'd2},
      '{1'b0, 8'b10101010, 2'd3, 1'b1, 8'd13},
      '{1'b0, 8'b01100110, 2'd1, 1'b0, 8'd10},
      '{1'b0, 8'b10100101, 2'd0, 1'b0, 8'd11},
      '{1'b0, 8'b10101010, 2'd1, 1'b1, 8'd13},
      '{1'b1, 8'b00000000, 2'd2, 1'b1, 8'd5},
      '{1'b1, 8'b01000000, 2'd0, 1'b1, 8'd6}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic access(input int f, input bit wr);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_frame = IW'(f);
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic load(input int f, input bit with_read);
      @(negedge clk);
      fill_valid = 1'b1; fill_frame = IW'(f);
      if (with_read) begin
         acc_valid = 1'b1; acc_write = 1'b0; acc_frame = IW'(f);
      end
      @(posedge clk);
      @(negedge clk);
      fill_valid = 1'b0; acc_valid = 1'b0;
   endtask

   task automatic pick(input int exp_idx, input int exp_dirty, input int exp_lat,
                       input bit side_wr, input int side_f, input string tag);
      int  cnt;
      bit  got;
      @(negedge clk);
      chk(req_ready == 1'b1, {"R11 ready idle ", tag}, int'(req_ready), 1);
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {"R11 busy ", tag}, int'(req_ready), 0);
      if (side_wr) begin
         acc_valid = 1'b1; acc_write = 1'b1; acc_frame = IW'(side_f);
      end
      cnt = 0; got = 1'b0;
      while (!got && cnt < 100) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         acc_valid = 1'b0; acc_write = 1'b0;
         if (done) got = 1'b1;
      end
      chk(int'(victim_frame) == exp_idx, {"R4/R8 frame ", tag}, int'(victim_frame), exp_idx);
      chk(int'(victim_dirty) == exp_dirty, {"R8 dirty ", tag}, int'(victim_dirty), exp_dirty);
      chk(cnt == exp_lat, {"R4/R7 examined ", tag}, cnt, exp_lat);
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, {"R11 single pulse ", tag}, int'(done), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      acc_valid = 1'b0; acc_write = 1'b0; acc_frame = '0;
      fill_valid = 1'b0; fill_frame = '0; req_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);

      // Table: rows cover R2, R4, R5, R6, R7, R8, R9 (hand carries over)
      foreach (ROWS[r]) begin
         if (!ROWS[r].keep) begin
            for (int f = 0; f < NF; f++) load(f, 1'b0);
         end
         for (int f = 0; f < NF; f++) begin
            case (ROWS[r].ops[2*f +: 2])
               2'd1: access(f, 1'b0);
               2'd2: access(f, 1'b1);
               default: ;
            endcase
         end
         pick(int'(ROWS[r].exp_idx), int'(ROWS[r].exp_dirty), int'(ROWS[r].exp_lat),
              1'b0, 0, $sformatf("row%0d", r));
      end

      // R10: write to the hand frame during the first scan cycle, hand=1
      for (int f = 0; f < NF; f++) load(f, 1'b0);
      for (int f = 0; f < NF; f++) access(f, 1'b0);
      pick(2, 0, 10, 1'b1, 1, "R10 write during search");

      // R3: a load clears a written frame, hand=3
      access(3, 1'b1);
      load(3, 1'b0);
      pick(3, 0, 1, 1'b0, 0, "R3 load clears");

      // R3: access and load to the same frame in one cycle, hand=0
      load(0, 1'b1);
      pick(2, 0, 3, 1'b0, 0, "R3 access beats load");

      // R1: reset mid-use clears bits and returns hand to 0
      for (int f = 0; f < NF; f++) access(f, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      pick(0, 0, 1, 1'b0, 0, "R1 reset clears state");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule